// File: doc/BRIEF.md
# Paged I2C Register Slave

This block is an I2C target that gives a bus master access to two pages of 8-bit registers. It watches SCL and SDA with the fast system clock. It decodes its own 7-bit device address and also answers the general call address. It pulls SDA low through an open-drain enable whenever it acknowledges or sends a zero bit.

A write starts with one pointer byte. Each data byte after it goes to the register at the pointer, and the pointer then moves on by one. A read sends the register at the pointer and advances it in the same way. A master usually writes the pointer, then issues a repeated START and reads from that point.

Register 0 looks the same from both pages, and its lowest bit chooses which page later accesses reach. Each accepted data byte also leaves the block as a one-cycle write strobe. A host-side read port lets on-chip logic look at any register.

Top module: `i2c_paged_regs`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR is acknowledged (SDA held low in the ninth clock), whatever the R/W bit (bit 0, 1 = read). Any other nonzero address byte gets no acknowledge, and the slave ignores the bus until the next START without changing any register.
- R2: The address byte 0x00 (general call) is acknowledged and handled exactly like a write to the slave's own address.
- R3: In a write, the first byte after the address loads the 7-bit pointer from its low seven bits, and bit 7 is ignored. Each later byte is stored at (active page, pointer) and acknowledged. For each such byte, wr_stb pulses for one cycle with wr_page, wr_addr and wr_data showing the target.
- R4: The pointer advances by one after every stored or transmitted byte, and goes from 127 back to 0 within the same page.
- R5: Register 0 is shared by both pages. Writing it sets the active page to bit 0 of the written byte, for all accesses that follow.
- R6: Bits 7..1 of register 0 are not stored and always read as zero, over I2C and on the host port.
- R7: After an address byte with R/W = 1, the slave sends the register at the pointer, MSB first, and advances the pointer. A master ACK asks for the next byte. A master NACK ends the read, and SDA is released.
- R8: A START or repeated START always restarts address reception, and the pointer survives a repeated START. A pointer write followed by a repeated START and a read therefore returns data from the written pointer.
- R9: A STOP or START that arrives inside a byte drops the partial byte: nothing is stored and no strobe is issued.
- R10: After reset SDA is released, the active page is 0, every register reads 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| wr_stb | output | 1 | One-cycle pulse per stored data byte |
| wr_page | output | 1 | Page of the stored byte |
| wr_addr | output | 7 | Register index of the stored byte |
| wr_data | output | 8 | Value of the stored byte |
| host_page | input | 1 | Page for the host read port |
| host_addr | input | 7 | Register index for the host read port |
| host_data | output | 8 | Register contents at host_page/host_addr |

## Verification
A wrong pointer shows up in the first data byte after it goes wrong: either as the wrong wr_addr on the strobe or as the wrong byte in the next read. The bench compares both against its model at once. A page bit in the wrong state sends a write to the wrong page, and a host read of both pages shows this right after the transaction. A bit counter that is out of step moves the acknowledge slot, and the master sees this as a missing ACK on the very byte where the error happens.

// File: rtl/i2cpr_pkg.sv
package i2cpr_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int NUM_PAGES = 2;
    localparam int PAGE_W    = $clog2(NUM_PAGES);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int CNT_W     = $clog2(DATA_W) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_NEXT,
        ST_WAIT
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic              we;
        logic [PAGE_W-1:0] page;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // own address in the upper seven bits, or the all-zero broadcast byte
    function automatic logic addr_hit(input logic [DATA_W-1:0] b,
                                      input logic [ADDR_W-1:0] dev);
        return (b[DATA_W-1:1] == dev) || (b == '0);
    endfunction

endpackage

// File: rtl/i2cpr_line_sync.sv
module i2cpr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES:0] scl_sh;
    logic [STAGES:0] sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[STAGES-1:0], sda_i};
        end
    end

    logic scl_prev, sda_prev;
    assign scl_lvl  = scl_sh[STAGES-1];
    assign sda_lvl  = sda_sh[STAGES-1];
    assign scl_prev = scl_sh[STAGES];
    assign sda_prev = sda_sh[STAGES];

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2cpr_engine.sv
module i2cpr_engine
    import i2cpr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [PAGE_W-1:0] cur_page,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sda_oe,
    output wr_req_t           wr_req
);
    bus_state_e        state;
    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] txreg;
    logic [ADDR_W-1:0] ptr;
    logic              is_read;

    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_ADDR;
            cnt     <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
            is_read <= 1'b0;
            sda_oe  <= 1'b0;
            wr_req  <= '0;
        end else begin
            wr_req.we <= 1'b0;
            if (start_evt) begin
                state  <= ST_RX;
                phase  <= PH_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_evt) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[DATA_W-2:0], sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_W'(DATA_W)) begin
                            cnt <= '0;
                            case (phase)
                                PH_ADDR: begin
                                    if (addr_hit(shreg, DEV_ADDR)) begin
                                        is_read <= shreg[0];
                                        sda_oe  <= 1'b1;
                                        state   <= ST_ACK;
                                    end else begin
                                        state <= ST_WAIT;
                                    end
                                end
                                PH_PTR: begin
                                    ptr    <= shreg[ADDR_W-1:0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end
                                default: begin
                                    wr_req.we   <= 1'b1;
                                    wr_req.page <= cur_page;
                                    wr_req.addr <= ptr;
                                    wr_req.data <= shreg;
                                    ptr         <= ptr + 1'b1;
                                    sda_oe      <= 1'b1;
                                    state       <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (phase == PH_ADDR && is_read) begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[DATA_W-1];
                                ptr    <= ptr + 1'b1;
                                cnt    <= '0;
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                                phase  <= (phase == PH_ADDR) ? PH_PTR : PH_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == CNT_W'(DATA_W - 1)) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                state  <= ST_MACK;
                            end else begin
                                txreg  <= {txreg[DATA_W-2:0], 1'b0};
                                sda_oe <= ~txreg[DATA_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            state <= sda_lvl ? ST_WAIT : ST_NEXT;
                        end
                    end
                    ST_NEXT: begin
                        if (scl_fall) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                            ptr    <= ptr + 1'b1;
                            cnt    <= '0;
                            state  <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cpr_page_file.sv
module i2cpr_page_file
    import i2cpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [PAGE_W-1:0] host_page,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [PAGE_W-1:0] cur_page,
    output logic [DATA_W-1:0] eng_data,
    output logic [DATA_W-1:0] host_data
);
    localparam int CELLS = NUM_PAGES * DEPTH;

    logic [DATA_W-1:0] mem [CELLS];
    logic [PAGE_W-1:0] page_q;

    assign cur_page = page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            for (int i = 0; i < CELLS; i++) mem[i] <= '0;
        end else if (wr_req.we) begin
            if (wr_req.addr == '0) page_q <= wr_req.data[PAGE_W-1:0];
            else mem[{wr_req.page, wr_req.addr}] <= wr_req.data;
        end
    end

    function automatic logic [DATA_W-1:0] fetch(input logic [PAGE_W-1:0] p,
                                                input logic [ADDR_W-1:0] a);
        if (a == '0) return {{(DATA_W-PAGE_W){1'b0}}, page_q};
        return mem[{p, a}];
    endfunction

    assign eng_data  = fetch(page_q, eng_addr);
    assign host_data = fetch(host_page, host_addr);

endmodule

// File: rtl/i2c_paged_regs.sv
module i2c_paged_regs
    import i2cpr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h18,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [PAGE_W-1:0] wr_page,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] host_page,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_data
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic [PAGE_W-1:0] cur_page;
    logic [ADDR_W-1:0] eng_addr;
    logic [DATA_W-1:0] eng_data;
    wr_req_t           wr_req;

    i2cpr_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2cpr_engine #(.DEV_ADDR(DEV_ADDR)) eng_i (
        .clk(clk), .rst(rst), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .cur_page(cur_page), .rd_data(eng_data), .rd_addr(eng_addr),
        .sda_oe(sda_oe), .wr_req(wr_req)
    );

    i2cpr_page_file file_i (
        .clk(clk), .rst(rst), .wr_req(wr_req), .eng_addr(eng_addr),
        .host_page(host_page), .host_addr(host_addr),
        .cur_page(cur_page), .eng_data(eng_data), .host_data(host_data)
    );

    assign wr_stb  = wr_req.we;
    assign wr_page = wr_req.page;
    assign wr_addr = wr_req.addr;
    assign wr_data = wr_req.data;

endmodule

// File: rtl/i2cpr_checker.sv
module i2cpr_checker
    import i2cpr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_lvl,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              sda_oe,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [PAGE_W-1:0] cur_page,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_data
);
    // R3
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R3
    wr_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !$past(scl_lvl));

    // R7
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(start_evt || stop_evt)) |-> !$past(scl_lvl));

    // R5
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_page) |-> $past(wr_stb && wr_addr == '0));

    // R6
    reg0_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (host_addr == '0) |-> (host_data[DATA_W-1:PAGE_W] == '0));

endmodule

bind i2c_paged_regs i2cpr_checker chk_i (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .start_evt(start_evt),
    .stop_evt(stop_evt), .sda_oe(sda_oe), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .cur_page(cur_page), .host_addr(host_addr),
    .host_data(host_data)
);

// File: tb/i2c_paged_regs_tb_top.sv
module i2c_paged_regs_tb_top;
    localparam int Q = 8;
    localparam logic [7:0] AW = 8'h30;
    localparam logic [7:0] AR = 8'h31;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe, wr_stb, wr_page;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;
    logic host_page = 1'b0;
    logic [6:0] host_addr = 7'd0;
    logic [7:0] host_data;

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_paged_regs dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .wr_stb(wr_stb), .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data),
        .host_page(host_page), .host_addr(host_addr), .host_data(host_data)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    int mem [256];
    int mpage = 0;
    int mptr = 0;
    logic [15:0] expq [$];

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every strobe is compared against the model's queue of expected writes
    always @(negedge clk) begin
        if (!rst && wr_stb) begin
            if (expq.size() == 0) chk("R3 R9 unexpected strobe", {wr_page, wr_addr, wr_data}, 0);
            else chk("R3 strobe", {wr_page, wr_addr, wr_data}, expq.pop_front());
        end
    end

    function automatic int mref(input int p, input int a);
        return (a == 0) ? mpage : mem[p * 128 + a];
    endfunction

    task automatic tick_q(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1; tick_q(); scl_m = 1; tick_q(); sda_m = 0; tick_q(); scl_m = 0; tick_q();
    endtask

    task automatic bus_stop();
        sda_m = 0; tick_q(); scl_m = 1; tick_q(); sda_m = 1; tick_q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick_q(); scl_m = 1; tick_q(); tick_q(); scl_m = 0; tick_q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1; tick_q(); scl_m = 1; tick_q(); ack = ~sda_bus; tick_q(); scl_m = 0; tick_q();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            tick_q(); scl_m = 1; tick_q(); b[i] = sda_bus; tick_q(); scl_m = 0;
        end
        tick_q(); sda_m = ~give_ack; tick_q(); scl_m = 1; tick_q(); tick_q(); scl_m = 0; tick_q();
        sda_m = 1;
    endtask

    task automatic model_write(input int d);
        expq.push_back({mpage[0], mptr[6:0], d[7:0]});
        if (mptr == 0) mpage = d & 1;
        else mem[mpage * 128 + mptr] = d;
        mptr = (mptr + 1) % 128;
    endtask

    task automatic wr_txn(input logic [7:0] abyte, input int ptr, input int n,
                          input int d0, input int d1, input int d2);
        bit ack;
        int d;
        bus_start();
        send_byte(abyte, ack); chk("R1 R2 address ack", ack, 1);
        send_byte(ptr[7:0], ack); chk("R3 pointer ack", ack, 1);
        mptr = ptr % 128;
        for (int k = 0; k < n; k++) begin
            d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            model_write(d);
            send_byte(d[7:0], ack); chk("R3 data ack", ack, 1);
        end
        bus_stop();
    endtask

    task automatic rd_txn(input bit set_ptr, input int ptr, input int n);
        bit ack;
        logic [7:0] b;
        if (set_ptr) begin
            bus_start();
            send_byte(AW, ack); chk("R1 address ack", ack, 1);
            send_byte(ptr[7:0], ack); chk("R8 pointer ack", ack, 1);
            mptr = ptr;
        end
        bus_start();
        send_byte(AR, ack); chk("R1 R8 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk("R7 R4 read byte", b, mref(mpage, mptr));
            mptr = (mptr + 1) % 128;
        end
        chk("R7 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic host_chk(input string req, input int p, input int a);
        host_page = p[0]; host_addr = a[6:0];
        @(negedge clk);
        chk(req, host_data, mref(p, a));
    endtask

    initial begin
        bit ack;
        for (int i = 0; i < 256; i++) mem[i] = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10 sda released", sda_oe, 0);
        host_chk("R10 reg0", 0, 0);
        host_chk("R10 reg5 page1", 1, 5);
        host_chk("R10 reg127", 0, 127);

        // R3 R4 burst write with own address
        wr_txn(AW, 5, 3, 8'hA1, 8'hB2, 8'hC3);
        for (int a = 5; a < 8; a++) host_chk("R3 R4 stored", 0, a);

        // R2 general call write, pointer bit 7 ignored (R3)
        wr_txn(8'h00, 8'h8A, 1, 8'h55, 0, 0);
        host_chk("R2 R3 general call stored", 0, 10);

        // R1 foreign address: no ack, no write
        bus_start();
        send_byte(8'h44, ack); chk("R1 foreign no ack", ack, 0);
        send_byte(8'h05, ack); chk("R1 ignored after miss", ack, 0);
        send_byte(8'hEE, ack);
        bus_stop();
        host_chk("R1 no change", 0, 5);

        // R5 R6 page select through register 0
        wr_txn(AW, 0, 1, 8'hFF, 0, 0);
        host_chk("R6 reg0 page0 view", 0, 0);
        host_chk("R5 R6 reg0 page1 view", 1, 0);
        wr_txn(AW, 5, 1, 8'h77, 0, 0);
        host_chk("R5 page1 written", 1, 5);
        host_chk("R5 page0 untouched", 0, 5);

        // R7 R8 read across repeated start
        rd_txn(1, 5, 3);

        // R4 wrap 127 -> 0 within page
        wr_txn(AW, 127, 2, 8'h9E, 8'h03, 0);
        host_chk("R4 wrap stored", 1, 127);
        rd_txn(1, 127, 2);

        // R5 back to page 0
        wr_txn(AW, 0, 1, 8'h00, 0, 0);
        rd_txn(1, 5, 3);

        // R9 STOP inside a data byte
        bus_start();
        send_byte(AW, ack); chk("R9 address ack", ack, 1);
        send_byte(8'd20, ack); chk("R9 pointer ack", ack, 1);
        mptr = 20;
        send_bits(8'hF0, 4);
        bus_stop();
        host_chk("R9 partial dropped", 0, 20);
        chk("R9 no pending strobe", expq.size(), 0);
        // R7 read from current pointer without setting it
        rd_txn(0, 0, 2);
        // R9 START inside a byte then a valid write
        bus_start();
        send_byte(AW, ack);
        send_bits(8'hAA, 3);
        wr_txn(AW, 30, 1, 8'h3C, 0, 0);
        host_chk("R8 R9 restart write", 0, 30);

        repeat (20) @(negedge clk);
        chk("R3 all strobes seen", expq.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule